// File: doc/BRIEF.md
# Multiplexed-Bus Cycle Master with Strobe Handshake

This block turns single requests from on-chip logic into target read and write cycles on a 16-bit local bus whose address and data share one set of AD lines. The requester presents a word address, a direction flag, two byte-lane enables, write data and a timeout limit, then pulses a start input. The master first places the address on AD and sets the direction line. It then lowers the address strobe, which slaves use to latch the address. Next it moves AD to the data phase and lowers the lane strobes for the selected bytes. It waits for the slave's acknowledge handshake.

The acknowledge input is synchronised through two flops and searched for edges. Its falling edge captures read data. Its rising edge ends the cycle. A loadable down-counter, started when the lane strobes fall, ends a cycle that the slave never finishes and sets a sticky timeout flag. After any ending, a new cycle is held off until the synchronised acknowledge is high again. A `bus_free` output tells the requester when a start will be taken.

Top module: `mbus_master`

## Requirements
- R1: While reset is held and after its release, the address strobe, both lane strobes and the direction line are high, AD is not driven, and `rsp_done`, `rsp_timeout` and `rsp_rdata` are zero.
- R2: A start pulse taken while `bus_free` is high puts `{req_addr, 1'b0}` on AD with the AD enable on and sets the direction line (high = read, low = write) in the following clock. One clock later the address strobe falls with the address and direction unchanged.
- R3: Through the whole cycle the direction line is stable while the address strobe is low. Lane strobes are low only while the address strobe is low. The upper strobe follows `req_be[1]` and the lower strobe `req_be[0]` (1 = lane selected). During the strobe phase a write drives its data on AD and a read leaves AD undriven.
- R4: The cycle ends on the third rising clock edge after the acknowledge input goes high. At that edge the address strobe, both lane strobes and the direction line return high and `rsp_done` rises.
- R5: With limit N, an unacknowledged cycle holds its lane strobes low for N+1 clocks, then ends as in R4 and sets `rsp_timeout`. The flag stays set until the next start is taken.
- R6: When the acknowledge rising edge and timer expiry fall on the same clock edge, the acknowledge wins and `rsp_timeout` stays clear.
- R7: In a read, AD is captured into `rsp_rdata` on the third rising edge after the acknowledge input falls, provided the cycle is still in its strobe phase there. Otherwise `rsp_rdata` keeps its previous value.
- R8: A start pulse is ignored while a cycle runs or while the synchronised acknowledge is low. `bus_free` is low in both cases.
- R9: `rsp_done` is high for exactly one clock per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_start | input | 1 | Start pulse for one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address (AD bits 15..1) |
| req_be | input | 2 | Lane enables: bit 1 upper, bit 0 lower |
| req_wdata | input | 16 | Write data |
| req_limit | input | 8 | Timeout limit N |
| rsp_rdata | output | 16 | Captured read data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_timeout | output | 1 | Sticky: last cycle ended by timeout |
| bus_free | output | 1 | A start would be taken now |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper lane strobe, active low |
| bus_lds_n | output | 1 | Lower lane strobe, active low |
| bus_rw_n | output | 1 | Direction: high read, low write |
| bus_ad_out | output | 16 | AD value driven by the master |
| bus_ad_oe | output | 1 | AD output enable |
| bus_ad_in | input | 16 | AD value seen on the bus |
| bus_dtack_n | input | 1 | Slave acknowledge, active low |

## Verification
The two endings of a cycle, the acknowledge rising edge and the expiry of the timeout counter, can land on the same clock edge. The bench provokes this with limit 6, pulling the acknowledge low as the strobes fall and releasing it four clocks later. It expects completion seven clocks after the strobes fall, no timeout flag, and captured read data. A companion vector releases the acknowledge one clock later and expects the same completion clock with the timeout flag set, so the priority is judged from both sides of the tie.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_ALAT = 3'd2,
    ST_DSET = 3'd3,
    ST_STRB = 3'd4,
    ST_DONE = 3'd5
  } mbm_state_e;

  // Active-low lane strobes for a given enable pair.
  function automatic logic [1:0] lane_strobes_n(input logic active, input logic [1:0] be);
    return active ? ~be : 2'b11;
  endfunction

  // A strobe phase finishes on either ending condition.
  function automatic logic cycle_ends(input logic rise, input logic expire);
    return rise | expire;
  endfunction

  // Expiry only counts as a timeout when no acknowledge edge shares the clock.
  function automatic logic timed_out(input logic rise, input logic expire);
    return expire & ~rise;
  endfunction

endpackage

// File: rtl/mbm_dtack_sync.sv
module mbm_dtack_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n_in,
  output logic ack_hi,
  output logic ack_rise,
  output logic ack_fall
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      last_q <= 1'b1;
    end else begin
      meta_q <= ack_n_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign ack_hi   = sync_q;
  assign ack_rise = sync_q & ~last_q;
  assign ack_fall = ~sync_q & last_q;
endmodule

// File: rtl/mbm_timer.sv
module mbm_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= limit;
    else if (run && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expire = run && (cnt_q == '0);

  // R5: a nonzero limit never expires on the first strobe clock
  p_fresh_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && limit != '0) |=> !expire);
endmodule

// File: rtl/mbm_seq.sv
module mbm_seq
  import mbm_pkg::*;
#(
  parameter int AD_W  = 16,
  parameter int TMO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [AD_W-2:0]   req_addr,
  input  logic [1:0]        req_be,
  input  logic [AD_W-1:0]   req_wdata,
  input  logic [TMO_W-1:0]  req_limit,
  input  logic              ack_hi,
  input  logic              ack_rise,
  input  logic              ack_fall,
  input  logic              tmr_expire,
  input  logic [AD_W-1:0]   ad_in,
  output logic              tmr_load,
  output logic              tmr_run,
  output logic [TMO_W-1:0]  limit_q,
  output logic [AD_W-1:0]   rdata_q,
  output logic              done_q,
  output logic              tmo_q,
  output logic              free,
  output logic              as_n_q,
  output logic              uds_n_q,
  output logic              lds_n_q,
  output logic              rw_n_q,
  output logic [AD_W-1:0]   ad_out_q,
  output logic              ad_oe_q
);
  localparam int WA_W = AD_W - 1;

  function automatic logic [AD_W-1:0] ad_word(input logic [WA_W-1:0] a);
    return {a, 1'b0};
  endfunction

  mbm_state_e state, nxt;
  logic            accept, cyc_end, end_by_tmo, rd_capture;
  logic            write_q, wr_sel;
  logic [WA_W-1:0] addr_q, addr_sel;
  logic [1:0]      be_q;
  logic [AD_W-1:0] wdata_q;

  always_comb begin
    nxt    = state;
    accept = 1'b0;
    unique case (state)
      ST_IDLE: if (req_start && ack_hi) begin
        nxt    = ST_ADDR;
        accept = 1'b1;
      end
      ST_ADDR: nxt = ST_ALAT;
      ST_ALAT: nxt = ST_DSET;
      ST_DSET: nxt = ST_STRB;
      ST_STRB: if (cycle_ends(ack_rise, tmr_expire)) nxt = ST_DONE;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign cyc_end    = (state == ST_STRB) && (nxt == ST_DONE);
  assign end_by_tmo = cyc_end && timed_out(ack_rise, tmr_expire);
  assign rd_capture = (state == ST_STRB) && ack_fall && !write_q;
  assign wr_sel     = accept ? req_write : write_q;
  assign addr_sel   = accept ? req_addr  : addr_q;
  assign tmr_load   = (state == ST_DSET);
  assign tmr_run    = (state == ST_STRB);
  assign free       = (state == ST_IDLE) && ack_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      write_q <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      limit_q <= '0;
    end else begin
      state <= nxt;
      if (accept) begin
        write_q <= req_write;
        addr_q  <= req_addr;
        be_q    <= req_be;
        wdata_q <= req_wdata;
        limit_q <= req_limit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_n_q   <= 1'b1;
      uds_n_q  <= 1'b1;
      lds_n_q  <= 1'b1;
      rw_n_q   <= 1'b1;
      ad_out_q <= '0;
      ad_oe_q  <= 1'b0;
    end else begin
      as_n_q <= !(nxt == ST_ALAT || nxt == ST_DSET || nxt == ST_STRB);
      {uds_n_q, lds_n_q} <= lane_strobes_n(nxt == ST_STRB, be_q);
      rw_n_q <= (nxt == ST_IDLE || nxt == ST_DONE) ? 1'b1 : !wr_sel;
      unique case (nxt)
        ST_ADDR, ST_ALAT: begin
          ad_out_q <= ad_word(addr_sel);
          ad_oe_q  <= 1'b1;
        end
        ST_DSET, ST_STRB: begin
          ad_out_q <= wr_sel ? wdata_q : '0;
          ad_oe_q  <= wr_sel;
        end
        default: begin
          ad_out_q <= '0;
          ad_oe_q  <= 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= cyc_end;
      if (accept)
        tmo_q <= 1'b0;
      else if (end_by_tmo)
        tmo_q <= 1'b1;
      if (rd_capture)
        rdata_q <= ad_in;
    end
  end

  // R3: lane strobes only inside the address strobe
  p_lanes_in_as_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!uds_n_q || !lds_n_q) |-> !as_n_q);
  // R3: direction held while address strobe stays low
  p_rw_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n_q && $past(!as_n_q)) |-> $stable(rw_n_q));
  // R3: a read never drives AD in its strobe phase
  p_read_floats_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!uds_n_q || !lds_n_q) && rw_n_q |-> !ad_oe_q);
  // R4: completion comes with every strobe released
  p_done_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (as_n_q && uds_n_q && lds_n_q && rw_n_q));
  // R5: the flag only rises together with completion
  p_flag_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> done_q);
  // R6: acknowledge edge beats a coincident expiry
  p_rise_beats_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STRB && ack_rise && tmr_expire) |=> (done_q && !tmo_q));
  // R8: no start while acknowledge is still low
  p_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !ack_hi) |=> as_n_q && !ad_oe_q);
  // R9: completion is a single clock
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/mbus_master.sv
module mbus_master #(
  parameter int AD_W  = 16,
  parameter int TMO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [AD_W-2:0]   req_addr,
  input  logic [1:0]        req_be,
  input  logic [AD_W-1:0]   req_wdata,
  input  logic [TMO_W-1:0]  req_limit,
  output logic [AD_W-1:0]   rsp_rdata,
  output logic              rsp_done,
  output logic              rsp_timeout,
  output logic              bus_free,
  output logic              bus_as_n,
  output logic              bus_uds_n,
  output logic              bus_lds_n,
  output logic              bus_rw_n,
  output logic [AD_W-1:0]   bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [AD_W-1:0]   bus_ad_in,
  input  logic              bus_dtack_n
);
  logic             ack_hi, ack_rise, ack_fall;
  logic             tmr_load, tmr_run, tmr_expire;
  logic [TMO_W-1:0] limit_q;

  mbm_dtack_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_n_in (bus_dtack_n),
    .ack_hi   (ack_hi),
    .ack_rise (ack_rise),
    .ack_fall (ack_fall)
  );

  mbm_timer #(.TMO_W(TMO_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .run    (tmr_run),
    .limit  (limit_q),
    .expire (tmr_expire)
  );

  mbm_seq #(.AD_W(AD_W), .TMO_W(TMO_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_start  (req_start),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_be     (req_be),
    .req_wdata  (req_wdata),
    .req_limit  (req_limit),
    .ack_hi     (ack_hi),
    .ack_rise   (ack_rise),
    .ack_fall   (ack_fall),
    .tmr_expire (tmr_expire),
    .ad_in      (bus_ad_in),
    .tmr_load   (tmr_load),
    .tmr_run    (tmr_run),
    .limit_q    (limit_q),
    .rdata_q    (rsp_rdata),
    .done_q     (rsp_done),
    .tmo_q      (rsp_timeout),
    .free       (bus_free),
    .as_n_q     (bus_as_n),
    .uds_n_q    (bus_uds_n),
    .lds_n_q    (bus_lds_n),
    .rw_n_q     (bus_rw_n),
    .ad_out_q   (bus_ad_out),
    .ad_oe_q    (bus_ad_oe)
  );
endmodule

// File: tb/mbus_master_test.sv
`timescale 1ns/1ps
module mbus_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0]  req_limit = '0;
  logic [15:0] rsp_rdata, bus_ad_out;
  logic        rsp_done, rsp_timeout, bus_free;
  logic        bus_as_n, bus_uds_n, bus_lds_n, bus_rw_n, bus_ad_oe;
  logic [15:0] bus_ad_in = '0;
  logic        bus_dtack_n = 1'b1;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_rd = '0;

  always #2.5 clk = ~clk;

  mbus_master uut (.*);

  typedef struct packed {
    logic        wr;
    logic [14:0] addr;
    logic [1:0]  be;
    logic [15:0] wdata;
    logic [15:0] sdata;
    int          ack;   // 255 = slave never answers
    int          hold;
    int          lim;
    logic        exp_tmo;
    int          exp_k;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 15'h1234, 2'b11, 16'hA5C3, 16'h0000, 2,   3, 20, 1'b0, 8},
    '{1'b0, 15'h7FFF, 2'b11, 16'h0000, 16'h5A3C, 1,   2, 20, 1'b0, 6},
    '{1'b0, 15'h0001, 2'b10, 16'h0000, 16'h1357, 0,   1, 15, 1'b0, 4},
    '{1'b1, 15'h2AAA, 2'b01, 16'h00FF, 16'h0000, 3,   2, 10, 1'b0, 8},
    '{1'b0, 15'h0040, 2'b11, 16'h0000, 16'hFFFF, 255, 0, 5,  1'b1, 6},
    '{1'b0, 15'h0123, 2'b11, 16'h0000, 16'h2468, 0,   4, 6,  1'b0, 7},
    '{1'b0, 15'h0456, 2'b01, 16'h0000, 16'h9BDF, 0,   5, 6,  1'b1, 7},
    '{1'b1, 15'h3333, 2'b10, 16'hC0DE, 16'h0000, 255, 0, 0,  1'b1, 1},
    '{1'b0, 15'h0777, 2'b11, 16'h0000, 16'h4444, 2,   6, 3,  1'b1, 4}
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  // Start a cycle and check the address phase (R2) and sticky flag clear (R5).
  task automatic start_op(input vec_t v);
    int guard = 0;
    @(negedge clk);
    while (!bus_free && guard < 50) begin @(negedge clk); guard++; end
    req_write = v.wr; req_addr = v.addr; req_be = v.be;
    req_wdata = v.wdata; req_limit = v.lim[7:0]; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk(bus_as_n && bus_ad_oe && bus_ad_out == {v.addr, 1'b0}, "R2 address phase", {15'd0, bus_ad_out, bus_as_n}, {15'd0, v.addr, 2'b01});
    chk(bus_rw_n == !v.wr, "R2 direction", bus_rw_n, !v.wr);
    chk(!rsp_timeout, "R5 flag cleared by start", rsp_timeout, 0);
    @(negedge clk);
    chk(!bus_as_n && bus_ad_out == {v.addr, 1'b0} && bus_uds_n && bus_lds_n, "R2 address strobe", {bus_ad_out, 3'd0, bus_as_n}, {v.addr, 1'b0, 4'd0});
  endtask

  task automatic run_vec(input vec_t v);
    logic seen = 1'b0, got_done = 1'b0;
    int k = 0, done_k = -1;
    int rise_k, end_k;
    logic exp_tmo;
    start_op(v);
    rise_k = (v.ack == 255) ? 1000 : v.ack + v.hold + 3;
    end_k  = (rise_k <= v.lim + 1) ? rise_k : v.lim + 1;
    exp_tmo = (rise_k > v.lim + 1);
    if (!v.wr && v.ack != 255 && v.ack + 3 <= end_k) exp_rd = v.sdata;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!seen && (!bus_uds_n || !bus_lds_n)) begin
        seen = 1'b1; k = 0;
        chk(bus_uds_n == !v.be[1] && bus_lds_n == !v.be[0], "R3 lane strobes", {bus_uds_n, bus_lds_n}, ~v.be);
        chk(!bus_as_n && bus_rw_n == !v.wr, "R3 strobe inside AS", {bus_as_n, bus_rw_n}, {1'b0, !v.wr});
        if (v.wr) chk(bus_ad_oe && bus_ad_out == v.wdata, "R3 write data", bus_ad_out, v.wdata);
        else      chk(!bus_ad_oe, "R3 read floats AD", bus_ad_oe, 0);
      end else if (seen) k++;
      if (seen && v.ack != 255) begin
        if (k == v.ack) begin bus_dtack_n = 1'b0; bus_ad_in = v.sdata; end
        if (k == v.ack + v.hold) bus_dtack_n = 1'b1;
      end
      if (rsp_done && !got_done) begin
        got_done = 1'b1; done_k = k;
        chk(done_k == v.exp_k && done_k == end_k, "R4 completion clock", done_k, v.exp_k);
        chk(bus_as_n && bus_uds_n && bus_lds_n && bus_rw_n && !bus_ad_oe, "R4 strobes released",
            {bus_as_n, bus_uds_n, bus_lds_n, bus_rw_n}, 4'hF);
        chk(rsp_timeout == v.exp_tmo && rsp_timeout == exp_tmo, "R5 R6 timeout flag", rsp_timeout, v.exp_tmo);
        chk(rsp_rdata == exp_rd, "R7 read data", rsp_rdata, exp_rd);
      end else if (got_done && i > 0 && k == done_k + 1) begin
        chk(!rsp_done, "R9 single done", rsp_done, 0);
      end
      if (got_done && k > done_k && (v.ack == 255 || k >= v.ack + v.hold)) break;
    end
    chk(got_done, "R4 cycle finished", got_done, 1);
    repeat (3) @(negedge clk);
    chk(rsp_timeout == v.exp_tmo, "R5 flag sticky while idle", rsp_timeout, v.exp_tmo);
    chk(!rsp_done, "R9 no extra done", rsp_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_as_n && bus_uds_n && bus_lds_n && bus_rw_n && !bus_ad_oe, "R1 strobes in reset",
        {bus_as_n, bus_uds_n, bus_lds_n, bus_rw_n, bus_ad_oe}, 5'h1E);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rsp_done && !rsp_timeout && rsp_rdata == 16'h0, "R1 response idle", {rsp_done, rsp_timeout, rsp_rdata}, 0);
    chk(bus_free, "R8 free after reset", bus_free, 1);

    for (int n = 0; n < NV; n++) run_vec(VECS[n]);

    // R8: acknowledge stuck low blocks a start
    bus_dtack_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bus_free, "R8 busy while ack low", bus_free, 0);
    req_write = 1'b1; req_addr = 15'h0055; req_be = 2'b11; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    begin
      logic moved = 1'b0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (!bus_as_n || bus_ad_oe) moved = 1'b1;
      end
      chk(!moved, "R8 start ignored while ack low", moved, 0);
    end
    bus_dtack_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(bus_free, "R8 free after release", bus_free, 1);

    // R8: a second start during a running cycle is dropped
    req_write = 1'b0; req_addr = 15'h0100; req_be = 2'b11; req_limit = 8'd8; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk(!bus_free, "R8 busy during cycle", bus_free, 0);
    @(negedge clk);
    req_write = 1'b1; req_addr = 15'h0200; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    begin
      logic bad = 1'b0, done_seen = 1'b0;
      for (int i = 0; i < 20 && !done_seen; i++) begin
        @(negedge clk);
        if (!bus_as_n && !bus_rw_n) bad = 1'b1;
        if (rsp_done) done_seen = 1'b1;
      end
      chk(done_seen && !bad, "R8 running read kept", {done_seen, bad}, 2'b10);
      bad = 1'b0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (!bus_as_n) bad = 1'b1;
      end
      chk(!bad, "R8 dropped start stays dropped", bad, 0);
    end
    report();
  end
endmodule